// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This combinational block sorts every 64-bit virtual address into one of three outcomes before any translation lookup happens. The address may be illegal for the current privilege and addressing mode, which raises an address error. It may lie in a window that bypasses translation, in which case the block forms the physical address and cache attribute directly. Otherwise it must be translated, and the block names the refill-vector class that a lookup miss would use.

The top two address bits split the space into a user window, a 64-bit supervisor window, a direct physical window and a kernel window. The kernel window holds both the 64-bit kernel mapped segment and, in its top 2 GiB, four 512 MiB compatibility segments. Privilege, the 64-bit addressing enable and the error-level flag decide which of these may be reached. The implemented virtual and physical widths are parameters.

Top module: `vseg_decoder`

## Requirements
- R1: For every input, exactly one of `addr_error`, `unmapped`, `mapped` is 1. `pa`, `cache_attr` and `refill_class` are all zero on an address error. `pa` and `cache_attr` are zero when mapped, and `refill_class` is zero when unmapped.
- R2: A user-window address (va[63:62]=00) is an address error when any bit at or above bit 31 is set with `xaddr_en`=0, or any bit at or above bit VW is set with `xaddr_en`=1. Otherwise it is mapped, unless R3 applies.
- R3: With `err_level`=1, a legal user-window address whose bits 63:32 are all zero is unmapped. Its `pa` is va[31:0] zero-extended and its `cache_attr` is 2 (uncached), in any privilege.
- R4: A supervisor-window address (va[63:62]=01) is an address error in user privilege, with `xaddr_en`=0, or when any bit from 61 down to VW is set. Otherwise it is mapped.
- R5: A physical-window address (va[63:62]=10) is legal only in kernel privilege with `xaddr_en`=1, with bits 58 down to PW all zero and the coherency field va[61:59] at most 6. Otherwise it is an address error.
- R6: A legal physical-window address is unmapped, with `pa`=va[PW-1:0] and `cache_attr`=va[61:59].
- R7: The compatibility segments are the addresses with va[63:31] all ones, selected by va[30:29] (00 cached kernel, 01 uncached kernel, 10 supervisor, 11 mapped kernel). User privilege may reach none of them. Supervisor privilege may reach only segment 10. Kernel privilege may reach all four.
- R8: Compatibility segments 00 and 01 are unmapped, with `pa`=va[28:0] zero-extended. Segment 00 takes `cache_attr`=`k0_attr`, and segment 01 takes `cache_attr`=2.
- R9: Any other kernel-window address is the 64-bit kernel mapped segment. It is mapped only in kernel privilege with `xaddr_en`=1 and va[61:0] below 2^VW − 2^31. Otherwise it is an address error.
- R10: `refill_class` is 0 for the user window, 1 for the supervisor window and compatibility segment 10, and 2 for the kernel mapped segment and compatibility segment 11.
- R11: `priv_mode` encodes 0 kernel, 1 supervisor, 2 user. The reserved code 3 is treated exactly as user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| va | input | 64 | Virtual address |
| priv_mode | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 and 3 user |
| xaddr_en | input | 1 | 64-bit addressing enable |
| err_level | input | 1 | Error-level flag (user window bypass) |
| k0_attr | input | 3 | Cache attribute for compatibility segment 00 |
| addr_error | output | 1 | Access is illegal |
| unmapped | output | 1 | Access bypasses translation |
| mapped | output | 1 | Access needs translation |
| pa | output | PW | Physical address when unmapped |
| cache_attr | output | 3 | Cache attribute when unmapped |
| refill_class | output | 2 | Refill class when mapped |

## Verification
The bench builds the decoder with its defaults, VW=40 and PW=36. These widths put the user-width limit at bit 40 and the physical-window limit at bit 36, so both can be probed just inside and just outside the legal range. They also place the kernel mapped segment end at a concrete address, 0xC00000FF80000000, which is tested on both sides. Sweeps of the coherency field and of every compatibility segment against every privilege code then cover the privilege rules exhaustively.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_RSVD   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    RC_USER   = 2'd0,
    RC_SUPER  = 2'd1,
    RC_KERNEL = 2'd2
  } refill_e;

  typedef enum logic [2:0] {
    SEG_USER,
    SEG_SUPER,
    SEG_PHYS,
    SEG_KMAP,
    SEG_C_K0,
    SEG_C_K1,
    SEG_C_SUP,
    SEG_C_K3
  } seg_e;

  typedef enum logic [1:0] {
    BYP_PHYS,
    BYP_USER_UNC,
    BYP_K0,
    BYP_K1
  } byp_e;

  localparam logic [2:0] ATTR_UNCACHED = 3'd2;
  localparam logic [2:0] CCA_MAX       = 3'd6;

  typedef struct packed {
    logic    hi_zero_31;
    logic    hi_zero_vw;
    logic    up32_zero;
    logic    sup_hi_zero;
    logic    phys_hi_zero;
    logic    kmap_in_range;
  } range_t;

endpackage

// File: rtl/vseg_region_dec.sv
module vseg_region_dec
  import vseg_pkg::*;
#(
  parameter int VW = 40,
  parameter int PW = 36
) (
  input  logic [63:0] va,
  output seg_e        seg,
  output range_t      rng
);

  localparam logic [61:0] KMAP_LIMIT = (62'd1 << VW) - (62'd1 << 31);

  logic compat;

  always_comb begin
    compat = &va[63:31];
    unique case (va[63:62])
      2'b00:   seg = SEG_USER;
      2'b01:   seg = SEG_SUPER;
      2'b10:   seg = SEG_PHYS;
      default: begin
        if (compat) begin
          unique case (va[30:29])
            2'b00:   seg = SEG_C_K0;
            2'b01:   seg = SEG_C_K1;
            2'b10:   seg = SEG_C_SUP;
            default: seg = SEG_C_K3;
          endcase
        end else begin
          seg = SEG_KMAP;
        end
      end
    endcase
  end

  always_comb begin
    rng.hi_zero_31    = ~|va[63:31];
    rng.hi_zero_vw    = ~|va[63:VW];
    rng.up32_zero     = ~|va[63:32];
    rng.sup_hi_zero   = ~|va[61:VW];
    rng.phys_hi_zero  = ~|va[58:PW];
    rng.kmap_in_range = (va[61:0] < KMAP_LIMIT);
  end

endmodule

// File: rtl/vseg_access_check.sv
module vseg_access_check
  import vseg_pkg::*;
(
  input  seg_e        seg,
  input  range_t      rng,
  input  logic [1:0]  priv_mode,
  input  logic        xaddr_en,
  input  logic        err_level,
  input  logic [2:0]  cca,
  output logic        err,
  output logic        bypass,
  output logic        map,
  output byp_e        byp_kind,
  output refill_e     cls
);

  logic is_kern;
  logic is_sup;
  logic is_user;

  // R11: reserved code folds into user
  always_comb begin
    is_kern = (priv_mode == PRIV_KERNEL);
    is_sup  = (priv_mode == PRIV_SUPER);
    is_user = !is_kern && !is_sup;
  end

  always_comb begin
    err      = 1'b0;
    bypass   = 1'b0;
    map      = 1'b0;
    byp_kind = BYP_PHYS;
    cls      = RC_USER;
    unique case (seg)
      SEG_USER: begin
        // R2, R3
        if (!(xaddr_en ? rng.hi_zero_vw : rng.hi_zero_31)) begin
          err = 1'b1;
        end else if (err_level && rng.up32_zero) begin
          bypass   = 1'b1;
          byp_kind = BYP_USER_UNC;
        end else begin
          map = 1'b1;
          cls = RC_USER;
        end
      end
      SEG_SUPER: begin
        // R4
        if (is_user || !xaddr_en || !rng.sup_hi_zero) begin
          err = 1'b1;
        end else begin
          map = 1'b1;
          cls = RC_SUPER;
        end
      end
      SEG_PHYS: begin
        // R5
        if (!is_kern || !xaddr_en || !rng.phys_hi_zero || (cca > CCA_MAX)) begin
          err = 1'b1;
        end else begin
          bypass   = 1'b1;
          byp_kind = BYP_PHYS;
        end
      end
      SEG_KMAP: begin
        // R9
        if (!is_kern || !xaddr_en || !rng.kmap_in_range) begin
          err = 1'b1;
        end else begin
          map = 1'b1;
          cls = RC_KERNEL;
        end
      end
      SEG_C_K0, SEG_C_K1: begin
        // R7, R8
        if (!is_kern) begin
          err = 1'b1;
        end else begin
          bypass   = 1'b1;
          byp_kind = (seg == SEG_C_K0) ? BYP_K0 : BYP_K1;
        end
      end
      SEG_C_SUP: begin
        if (is_user) begin
          err = 1'b1;
        end else begin
          map = 1'b1;
          cls = RC_SUPER;
        end
      end
      default: begin
        if (!is_kern) begin
          err = 1'b1;
        end else begin
          map = 1'b1;
          cls = RC_KERNEL;
        end
      end
    endcase
  end

endmodule

// File: rtl/vseg_pa_form.sv
module vseg_pa_form
  import vseg_pkg::*;
#(
  parameter int PW = 36
) (
  input  logic [63:0]   va,
  input  logic [2:0]    k0_attr,
  input  logic          bypass,
  input  byp_e          byp_kind,
  output logic [PW-1:0] pa,
  output logic [2:0]    cache_attr
);

  logic [PW-1:0] user_pa;
  logic [PW-1:0] compat_pa;

  // zero-extension of the low windows; width picks the variant
  generate
    if (PW > 32) begin : g_wide
      assign user_pa   = {{(PW-32){1'b0}}, va[31:0]};
    end else begin : g_narrow
      assign user_pa   = va[PW-1:0];
    end
  endgenerate
  assign compat_pa = {{(PW-29){1'b0}}, va[28:0]};

  always_comb begin
    pa         = '0;
    cache_attr = 3'd0;
    if (bypass) begin
      unique case (byp_kind)
        BYP_PHYS: begin
          pa         = va[PW-1:0];
          cache_attr = va[61:59];
        end
        BYP_USER_UNC: begin
          pa         = user_pa;
          cache_attr = ATTR_UNCACHED;
        end
        BYP_K0: begin
          pa         = compat_pa;
          cache_attr = k0_attr;
        end
        default: begin
          pa         = compat_pa;
          cache_attr = ATTR_UNCACHED;
        end
      endcase
    end
  end

endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vseg_pkg::*;
#(
  parameter int VW = 40,
  parameter int PW = 36
) (
  input  logic [63:0]   va,
  input  logic [1:0]    priv_mode,
  input  logic          xaddr_en,
  input  logic          err_level,
  input  logic [2:0]    k0_attr,
  output logic          addr_error,
  output logic          unmapped,
  output logic          mapped,
  output logic [PW-1:0] pa,
  output logic [2:0]    cache_attr,
  output logic [1:0]    refill_class
);

  seg_e    seg;
  range_t  rng;
  logic    err;
  logic    bypass;
  logic    map;
  byp_e    byp_kind;
  refill_e cls;

  vseg_region_dec #(.VW(VW), .PW(PW)) u_region (
    .va  (va),
    .seg (seg),
    .rng (rng)
  );

  vseg_access_check u_access (
    .seg       (seg),
    .rng       (rng),
    .priv_mode (priv_mode),
    .xaddr_en  (xaddr_en),
    .err_level (err_level),
    .cca       (va[61:59]),
    .err       (err),
    .bypass    (bypass),
    .map       (map),
    .byp_kind  (byp_kind),
    .cls       (cls)
  );

  vseg_pa_form #(.PW(PW)) u_pa (
    .va         (va),
    .k0_attr    (k0_attr),
    .bypass     (bypass),
    .byp_kind   (byp_kind),
    .pa         (pa),
    .cache_attr (cache_attr)
  );

  // R1, R10
  always_comb begin
    addr_error   = err;
    unmapped     = bypass;
    mapped       = map;
    refill_class = map ? cls : RC_USER;
  end

endmodule

// File: rtl/vseg_decoder_chk.sv
module vseg_decoder_chk #(
  parameter int VW = 40,
  parameter int PW = 36
) (
  input logic [63:0]   va,
  input logic [1:0]    priv_mode,
  input logic          err_level,
  input logic          addr_error,
  input logic          unmapped,
  input logic          mapped,
  input logic [PW-1:0] pa,
  input logic [2:0]    cache_attr,
  input logic [1:0]    refill_class
);

  always_comb begin
    // R1
    flags_onehot_chk: assert ($countones({addr_error, unmapped, mapped}) == 1);
    // R1
    err_quiet_chk: assert (!addr_error || (pa == '0 && cache_attr == 3'd0 && refill_class == 2'd0));
    // R1
    map_quiet_chk: assert (!mapped || (pa == '0 && cache_attr == 3'd0));
    // R11
    user_reach_chk: assert (!(priv_mode[1] && va[63:62] != 2'b00) || addr_error);
    // R6
    phys_pass_chk: assert (!(unmapped && va[63:62] == 2'b10) ||
                           (pa == va[PW-1:0] && cache_attr == va[61:59]));
    // R3
    erl_bypass_chk: assert (!(err_level && va[63:31] == 33'd0) ||
                            (unmapped && cache_attr == 3'd2));
    // R10
    user_class_chk: assert (!(mapped && va[63:62] == 2'b00) || refill_class == 2'd0);
  end

endmodule

bind vseg_decoder vseg_decoder_chk #(.VW(VW), .PW(PW)) u_chk (
  .va           (va),
  .priv_mode    (priv_mode),
  .err_level    (err_level),
  .addr_error   (addr_error),
  .unmapped     (unmapped),
  .mapped       (mapped),
  .pa           (pa),
  .cache_attr   (cache_attr),
  .refill_class (refill_class)
);

// File: tb/tb_vseg_decoder.sv
module tb_vseg_decoder;

  localparam int VW = 40;
  localparam int PW = 36;
  localparam int NV = 33;
  localparam logic [1:0] K_ERR = 2'd0, K_UNM = 2'd1, K_MAP = 2'd2;

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  md;
    logic        x;
    logic        e;
    logic [2:0]  k0;
    logic [1:0]  kind;
    logic [35:0] pa;
    logic [2:0]  attr;
    logic [1:0]  cls;
    logic [3:0]  req;
  } vec_t;

  // kind: 0 error, 1 unmapped, 2 mapped; mode 0 K, 1 S, 2 U, 3 reserved
  localparam vec_t VECS [0:NV-1] = '{
    '{64'h0000_0000_1234_5678, 2'd2, 1'b0, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd0, 4'd2},  // R2 R10
    '{64'h0000_0000_8000_0000, 2'd2, 1'b0, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd2},  // R2
    '{64'h0000_0000_8000_0000, 2'd2, 1'b1, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd0, 4'd2},  // R2
    '{64'h0000_00FF_FFFF_F000, 2'd2, 1'b1, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd0, 4'd2},  // R2
    '{64'h0000_0100_0000_0000, 2'd0, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd2},  // R2
    '{64'h0000_0000_0001_2340, 2'd0, 1'b0, 1'b1, 3'd0, K_UNM, 36'h0_0001_2340, 3'd2, 2'd0, 4'd3}, // R3
    '{64'h0000_0001_0000_0000, 2'd0, 1'b1, 1'b1, 3'd0, K_MAP, 36'h0, 3'd0, 2'd0, 4'd3},  // R3
    '{64'h4000_0000_0000_1000, 2'd1, 1'b1, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd1, 4'd4},  // R4 R10
    '{64'h4000_0000_0000_1000, 2'd2, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd4},  // R4
    '{64'h4000_0000_0000_1000, 2'd1, 1'b0, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd4},  // R4
    '{64'h4000_0100_0000_0000, 2'd0, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd4},  // R4
    '{64'h9800_0001_2345_6780, 2'd0, 1'b1, 1'b0, 3'd0, K_UNM, 36'h1_2345_6780, 3'd3, 2'd0, 4'd6}, // R6
    '{64'h9800_0001_2345_6780, 2'd0, 1'b0, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd5},  // R5
    '{64'h9800_0001_2345_6780, 2'd1, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd5},  // R5
    '{64'h9800_0010_0000_0000, 2'd0, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd5},  // R5
    '{64'hB800_0000_0000_0000, 2'd0, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd5},  // R5
    '{64'hB000_0000_0000_0040, 2'd0, 1'b1, 1'b0, 3'd0, K_UNM, 36'h40, 3'd6, 2'd0, 4'd6}, // R6
    '{64'hFFFF_FFFF_8000_1000, 2'd0, 1'b0, 1'b0, 3'd3, K_UNM, 36'h1000, 3'd3, 2'd0, 4'd8}, // R8
    '{64'hFFFF_FFFF_A000_2000, 2'd0, 1'b0, 1'b0, 3'd3, K_UNM, 36'h2000, 3'd2, 2'd0, 4'd8}, // R8
    '{64'hFFFF_FFFF_C000_0000, 2'd1, 1'b0, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd1, 4'd7},  // R7
    '{64'hFFFF_FFFF_E000_0000, 2'd1, 1'b0, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd7},  // R7
    '{64'hFFFF_FFFF_E000_0000, 2'd0, 1'b0, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd2, 4'd10}, // R10
    '{64'hFFFF_FFFF_8000_0000, 2'd2, 1'b0, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd7},  // R7
    '{64'hFFFF_FFFF_8000_0000, 2'd1, 1'b0, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd7},  // R7
    '{64'hC000_0000_0000_0000, 2'd0, 1'b1, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd2, 4'd9},  // R9
    '{64'hC000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd9},  // R9
    '{64'hC000_00FF_7FFF_FFFF, 2'd0, 1'b1, 1'b0, 3'd0, K_MAP, 36'h0, 3'd0, 2'd2, 4'd9},  // R9
    '{64'hC000_00FF_8000_0000, 2'd0, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd9},  // R9
    '{64'hC000_0000_0000_0000, 2'd1, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd9},  // R9
    '{64'h4000_0000_0000_1000, 2'd3, 1'b1, 1'b0, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd11}, // R11
    '{64'h0000_0000_0000_0100, 2'd2, 1'b0, 1'b1, 3'd0, K_UNM, 36'h100, 3'd2, 2'd0, 4'd3}, // R3
    '{64'h0000_0000_8000_0000, 2'd2, 1'b0, 1'b1, 3'd0, K_ERR, 36'h0, 3'd0, 2'd0, 4'd2},  // R2
    '{64'hFFFF_FFFF_9FFF_FFFF, 2'd0, 1'b1, 1'b0, 3'd5, K_UNM, 36'h1FFF_FFFF, 3'd5, 2'd0, 4'd8} // R8
  };

  logic          clk;
  logic          rst_n;
  logic [63:0]   va;
  logic [1:0]    priv_mode;
  logic          xaddr_en;
  logic          err_level;
  logic [2:0]    k0_attr;
  logic          addr_error;
  logic          unmapped;
  logic          mapped;
  logic [PW-1:0] pa;
  logic [2:0]    cache_attr;
  logic [1:0]    refill_class;

  int checks;
  int failures;
  bit done;

  vseg_decoder #(.VW(VW), .PW(PW)) dut (
    .va           (va),
    .priv_mode    (priv_mode),
    .xaddr_en     (xaddr_en),
    .err_level    (err_level),
    .k0_attr      (k0_attr),
    .addr_error   (addr_error),
    .unmapped     (unmapped),
    .mapped       (mapped),
    .pa           (pa),
    .cache_attr   (cache_attr),
    .refill_class (refill_class)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic apply(input logic [63:0] a, input logic [1:0] m, input logic x,
                       input logic e, input logic [2:0] k0);
    @(posedge clk);
    va        <= a;
    priv_mode <= m;
    xaddr_en  <= x;
    err_level <= e;
    k0_attr   <= k0;
    @(negedge clk);
  endtask

  task automatic check_out(input logic [1:0] kind, input logic [35:0] epa,
                           input logic [2:0] eattr, input logic [1:0] ecls,
                           input int req, input int idx);
    logic [2:0] eflags;
    eflags = (kind == K_ERR) ? 3'b100 : (kind == K_UNM) ? 3'b010 : 3'b001;
    checks++;
    if ({addr_error, unmapped, mapped} !== eflags || pa !== epa[PW-1:0] ||
        cache_attr !== eattr || refill_class !== ecls) begin
      failures++;
      $display("FAIL R%0d case %0d: got flags=%b pa=%h attr=%0d cls=%0d exp flags=%b pa=%h attr=%0d cls=%0d",
               req, idx, {addr_error, unmapped, mapped}, pa, cache_attr, refill_class,
               eflags, epa[PW-1:0], eattr, ecls);
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    va = '0; priv_mode = 2'd0; xaddr_en = 1'b0; err_level = 1'b0; k0_attr = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // R1 R10: idle inputs decode to a mapped user-window access
    check_out(K_MAP, 36'h0, 3'd0, 2'd0, 1, -1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].va, VECS[i].md, VECS[i].x, VECS[i].e, VECS[i].k0);
      check_out(VECS[i].kind, VECS[i].pa, VECS[i].attr, VECS[i].cls, int'(VECS[i].req), i);
    end

    // R5 R6: coherency field sweep in the physical window
    for (int c = 0; c < 8; c++) begin
      apply({2'b10, 3'(c), 59'h0000_0000_0000_ABC}, 2'd0, 1'b1, 1'b0, 3'd0);
      if (c <= 6) check_out(K_UNM, 36'hABC, 3'(c), 2'd0, 6, 100 + c);
      else        check_out(K_ERR, 36'h0, 3'd0, 2'd0, 5, 100 + c);
    end

    // R7 R8 R11: every compatibility segment against every privilege code
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 4; m++) begin
        apply({33'h1_FFFF_FFFF, 2'(r), 29'h100}, 2'(m), 1'b0, 1'b0, 3'd4);
        if (m >= 2)
          check_out(K_ERR, 36'h0, 3'd0, 2'd0, 11, 200 + 4 * r + m);
        else if (m == 1)
          check_out(r == 2 ? K_MAP : K_ERR, 36'h0, 3'd0, r == 2 ? 2'd1 : 2'd0, 7, 200 + 4 * r + m);
        else if (r == 0)
          check_out(K_UNM, 36'h100, 3'd4, 2'd0, 8, 200 + 4 * r + m);
        else if (r == 1)
          check_out(K_UNM, 36'h100, 3'd2, 2'd0, 8, 200 + 4 * r + m);
        else
          check_out(K_MAP, 36'h0, 3'd0, r == 2 ? 2'd1 : 2'd2, 7, 200 + 4 * r + m);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule